// File: doc/BRIEF.md
# Reset Sequencer with Cause Recording

This block merges five reset requests into one stretched internal reset. The requests are power-on, external pin, supply brown-out, watchdog timeout and a debug-port reset. Each request arrives already synchronised to the block clock. Power-on, external, brown-out and debug are level requests that stay high as long as their condition lasts. The watchdog request is a single-cycle pulse. The internal reset output is registered. It is high while any request is present, and it stays high for a fixed, parameterised number of clock cycles after the last request goes away. For a watchdog pulse, that delay starts when the pulse falls.

Alongside the reset, the block keeps a five-bit cause record that software reads and clears through a byte-wide register port. A non-power-on reset leaves the earlier flags in place, so after the reset, software can see every source that fired since it last cleared the record. A power-on request restarts the record. It discards the old flags and records power-on together with any other request present in the same cycle. The power-on request also serves as the block's own synchronous, active-high reset.

Top module: `rst_cause_ctrl`

## Requirements
- R1: The cause byte read at `reg_rdata` places the flags as follows: debug at bit 4, watchdog at bit 3, brown-out at bit 2, external at bit 1 and power-on at bit 0. Bits 7 to 5 always read as zero.
- R2: When an external, brown-out, watchdog or debug request is sampled high at a clock edge, its flag reads one after that edge.
- R3: A power-on request sampled at an edge leaves the record holding power-on at bit 0 plus exactly the other requests sampled at that edge. All older flags are cleared.
- R4: A register write (`reg_we` high) clears every flag whose `reg_wdata` bit is zero. A one in the write data has no effect, and bits 7 to 5 of the write data are ignored.
- R5: External, brown-out, watchdog and debug resets leave all existing flags unchanged, including the power-on flag. The power-on flag is cleared only by a software write of zero.
- R6: If a write clears a flag in the same cycle that its source request is sampled, the flag stays set.
- R7: `rst_o` is high after any edge at which a request is sampled. It stays high for as long as a level request is held.
- R8: Let a request be sampled at an edge, with no request at the following HOLD_CYCLES edges. Then `rst_o` stays high through those HOLD_CYCLES edges and is low after the next edge. This includes a one-cycle watchdog pulse, whose delay therefore starts at the pulse's falling edge.
- R9: When several requests are sampled at the same edge, every matching flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_req | input | 1 | Power-on request; also the block's synchronous active-high reset |
| ext_req | input | 1 | External pin reset request (level) |
| bod_req | input | 1 | Brown-out reset request (level) |
| wdt_pulse | input | 1 | Watchdog timeout, one-cycle pulse |
| dbg_req | input | 1 | Debug-port reset request (level) |
| reg_we | input | 1 | Write strobe for the cause byte |
| reg_wdata | input | 8 | Write data; a zero bit clears the matching flag |
| reg_rdata | output | 8 | Cause byte read data |
| rst_o | output | 1 | Stretched internal reset |

## Verification
The bench builds the block with HOLD_CYCLES set to 3. With that value, the falling edge of the reset can be checked exactly for every request pattern without long waits. The bench sweeps all fifteen non-empty combinations of the four non-power-on sources, holding each level request for two cycles and giving the watchdog a single pulse. After every clock edge, it compares both the cause byte and the reset output against a reference computed in the bench. Directed cases on top of the sweep cover writes that clear and writes that try to set flags, a clear that collides with a new request, and a power-on request that coincides with an external request.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int NUM_SRC = 5;
  localparam int REG_W   = 8;

  // flag positions inside the cause byte
  localparam int IDX_POR = 0;
  localparam int IDX_EXT = 1;
  localparam int IDX_BOD = 2;
  localparam int IDX_WDT = 3;
  localparam int IDX_DBG = 4;

  typedef logic [NUM_SRC-1:0] cause_t;
endpackage

// File: rtl/rcc_req_merge.sv
module rcc_req_merge
  import rcc_pkg::*;
(
  input  logic   por_req,
  input  logic   ext_req,
  input  logic   bod_req,
  input  logic   wdt_pulse,
  input  logic   dbg_req,
  output cause_t set_vec,
  output logic   any_req
);
  always_comb begin
    set_vec          = '0;
    set_vec[IDX_POR] = por_req;
    set_vec[IDX_EXT] = ext_req;
    set_vec[IDX_BOD] = bod_req;
    set_vec[IDX_WDT] = wdt_pulse;
    set_vec[IDX_DBG] = dbg_req;
    any_req          = |set_vec;
  end
endmodule

// File: rtl/rcc_hold_timer.sv
module rcc_hold_timer #(
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic por_req,
  input  logic any_req,
  output logic rst_o
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (any_req) begin
      cnt   <= LOAD;
      rst_o <= 1'b1;
    end else if (cnt != '0) begin
      cnt   <= cnt - 1'b1;
      rst_o <= 1'b1;
    end else begin
      rst_o <= 1'b0;
    end
  end

  AST_REQ_HOLDS_RST: assert property (@(posedge clk) disable iff (por_req)
    any_req |=> rst_o); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (por_req)
    any_req |=> (cnt <= LOAD)); // R8
  AST_STRETCH_ACTIVE: assert property (@(posedge clk) disable iff (por_req)
    (!any_req && cnt != '0) |=> rst_o); // R8
  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (por_req)
    (!any_req && cnt == '0) |=> !rst_o); // R8
endmodule

// File: rtl/rcc_cause_reg.sv
module rcc_cause_reg
  import rcc_pkg::*;
(
  input  logic               clk,
  input  logic               por_req,
  input  cause_t             set_vec,
  input  logic               reg_we,
  input  cause_t             wr_bits,
  output logic [REG_W-1:0]   reg_rdata
);
  cause_t flags;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    if (i == IDX_POR) begin : g_por
      // power-on flag: only a software zero clears it
      always_ff @(posedge clk) begin
        if (set_vec[i])                flags[i] <= 1'b1;
        else if (reg_we && !wr_bits[i]) flags[i] <= 1'b0;
      end
    end else begin : g_src
      always_ff @(posedge clk) begin
        if (por_req)                   flags[i] <= set_vec[i];
        else if (set_vec[i])           flags[i] <= 1'b1;
        else if (reg_we && !wr_bits[i]) flags[i] <= 1'b0;
      end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (por_req)
      set_vec[i] |=> flags[i]); // R6
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (por_req)
      !set_vec[i] |=> !$rose(flags[i])); // R4
  end

  always_comb begin
    reg_rdata              = '0;
    reg_rdata[NUM_SRC-1:0] = flags;
  end
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic             clk,
  input  logic             por_req,
  input  logic             ext_req,
  input  logic             bod_req,
  input  logic             wdt_pulse,
  input  logic             dbg_req,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             rst_o
);
  cause_t set_vec;
  logic   any_req;
  logic   unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[REG_W-1:NUM_SRC];

  rcc_req_merge u_merge (
    .por_req  (por_req),
    .ext_req  (ext_req),
    .bod_req  (bod_req),
    .wdt_pulse(wdt_pulse),
    .dbg_req  (dbg_req),
    .set_vec  (set_vec),
    .any_req  (any_req)
  );

  rcc_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk    (clk),
    .por_req(por_req),
    .any_req(any_req),
    .rst_o  (rst_o)
  );

  rcc_cause_reg u_cause (
    .clk      (clk),
    .por_req  (por_req),
    .set_vec  (set_vec),
    .reg_we   (reg_we),
    .wr_bits  (reg_wdata[NUM_SRC-1:0]),
    .reg_rdata(reg_rdata)
  );

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (por_req)
    reg_we |=> (reg_rdata[REG_W-1:NUM_SRC] == '0)); // R1
endmodule

// File: tb/rst_cause_ctrl_test.sv
module rst_cause_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 3;

  logic clk = 1'b0;
  logic por_req = 1'b1, ext_req = 1'b0, bod_req = 1'b0, wdt_pulse = 1'b0, dbg_req = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic rst_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [4:0] exp_flags = 5'h00;
  int since = 1000;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_ctrl #(.HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .por_req(por_req), .ext_req(ext_req), .bod_req(bod_req),
    .wdt_pulse(wdt_pulse), .dbg_req(dbg_req), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_o(rst_o)
  );

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // one clock edge: predict from the sampled inputs, then compare
  task automatic tick(string tag_flags, string tag_rst);
    logic [4:0] req;
    logic [4:0] nxt;
    req = {dbg_req, wdt_pulse, bod_req, ext_req, por_req};
    if (por_req) nxt = req;
    else begin
      nxt = exp_flags;
      if (reg_we) nxt = nxt & reg_wdata[4:0];
      nxt = nxt | req;
    end
    exp_flags = nxt;
    if (req != 0) since = 0;
    else if (since < 1000) since++;
    @(posedge clk);
    @(negedge clk);
    check8(tag_flags, reg_rdata, {3'b000, exp_flags});
    check8(tag_rst, {7'd0, rst_o}, {7'd0, (since <= HOLD)});
  endtask

  task automatic write(logic [7:0] d, string tag);
    reg_we = 1'b1; reg_wdata = d;
    tick(tag, "R8");
    reg_we = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) tick(tag, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    // power-on: record restarts at 0x01 (R3), reset held (R7)
    tick("R3", "R7");
    tick("R3", "R7");
    check8("R3 reset state", reg_rdata, 8'h01);
    por_req = 1'b0;
    idle(HOLD + 2, "R5");
    check8("R8 released after power-on", {7'd0, rst_o}, 8'h00);

    // external reset keeps power-on flag: 0x03 (R5, R2)
    ext_req = 1'b1; tick("R2", "R7"); ext_req = 1'b0;
    idle(HOLD + 2, "R5");
    check8("R5 por flag kept", reg_rdata, 8'h03);

    // writes: 0xFE clears only bit0 -> 0x02, 0xFF no effect, 0x00 clears (R4, R1)
    write(8'hFE, "R4");
    check8("R4 zero clears bit0", reg_rdata, 8'h02);
    write(8'hFF, "R4");
    check8("R1 ones ignored, upper bits zero", reg_rdata, 8'h02);
    write(8'h1F, "R4");
    write(8'h00, "R4");
    check8("R4 all cleared", reg_rdata, 8'h00);

    // sweep all source combinations: dbg=bit3, wdt=bit2, bod=bit1, ext=bit0 of m
    for (int m = 1; m < 16; m++) begin
      ext_req = m[0]; bod_req = m[1]; wdt_pulse = m[2]; dbg_req = m[3];
      tick("R9", "R7");
      wdt_pulse = 1'b0;
      tick("R2", "R7");
      ext_req = 1'b0; bod_req = 1'b0; dbg_req = 1'b0;
      idle(HOLD + 2, "R8");
      check8("R9 combination flags", reg_rdata, {3'b000, m[3], m[2], m[1], m[0], 1'b0});
      if (m != 15) write(8'hE0, "R4");
    end

    // clear of watchdog bit colliding with a new pulse: bit stays (R6)
    reg_we = 1'b1; reg_wdata = 8'hF7; wdt_pulse = 1'b1;
    tick("R6", "R7");
    reg_we = 1'b0; reg_wdata = 8'h00; wdt_pulse = 1'b0;
    check8("R6 set beats clear", reg_rdata, 8'h1E);
    idle(HOLD + 2, "R8");

    // power-on with external in same cycle: old flags gone, 0x03 (R3)
    por_req = 1'b1; ext_req = 1'b1;
    tick("R3", "R7");
    por_req = 1'b0; ext_req = 1'b0;
    check8("R3 power-on restarts record", reg_rdata, 8'h03);
    idle(HOLD + 2, "R8");
    check8("R8 final release", {7'd0, rst_o}, 8'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule